// File: doc/BRIEF.md
# AXI Transaction ID Remapper

This block sits between upstream bus masters and a coherency port that takes only 3-bit transaction IDs. Each read or write address carries a 12-bit ID. The block picks an output ID for it and presents that ID with the address. When the response comes back on an output ID, the block restores the original 12-bit ID. Read and write traffic use separate tables and separate counters.

Software can pin a chosen 12-bit ID to one of the output IDs 2 to 6, separately for reads and for writes. Output IDs 0, 1 and 7 are always allocated on demand. Output ID 7 is never pinned, so a dynamic slot can always free up and the system cannot deadlock. A mapping change is held back until the target output ID has nothing outstanding on that channel. While the change waits, that output ID takes no new traffic. A per-register done bit tells software when the change has taken effect.

Top module: `axi_id_remap`

## Requirements
- R1: After reset every output ID is dynamic with zero outstanding, all done and fixed bits read 0, and the first address on either channel gets output ID 0.
- R2: A register write (cfg_we_i=1) whose cfg_vid_i is 0, 1 or 7 is ignored: no fixed or done bit changes, and allocation still treats those IDs as dynamic.
- R3: A register write to output ID 2..6 becomes pending. It is applied on the next clock edge at which that output ID has zero outstanding on the selected channel and accepts no address. Until then the previous mapping stays in force.
- R4: A register write clears that register's done bit on the next edge. The bit goes to 1 on the edge that applies the change and holds until the next write to the same register. The fixed bit shows the applied force value.
- R5: An address whose ID equals the applied master ID of a fixed output ID goes to that output ID, unless the same ID is still outstanding on a dynamic slot.
- R6: An address whose ID is outstanding on a non-fixed output ID goes to that same output ID, so responses for one ID keep their order.
- R7: Any other address goes to the lowest-numbered output ID that is not fixed, not pending and has zero outstanding. If there is no such ID, ready stays low. Output ID 7 always stays dynamic.
- R8: Each output ID has a 4-bit outstanding count. It goes up on address acceptance and down on a read response with last=1 or on a write response. At 15 it accepts no further address.
- R9: r_id_o and b_id_o give the 12-bit ID last accepted on the output ID named by r_vid_i or b_vid_i.
- R10: cfg_wr_i selects the table (0 = read registers, 1 = write registers). Mappings, counts and done bits of the two channels are independent.
- R11: An output ID with a pending change accepts no new address. An ID that would go to it stalls instead of moving elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ar_valid_i | input | 1 | Read address valid |
| ar_id_i | input | 12 | Read address input ID |
| ar_ready_o | output | 1 | Read address accepted when high with valid |
| ar_vid_o | output | 3 | Output ID chosen for the read |
| r_valid_i | input | 1 | Read response beat valid |
| r_last_i | input | 1 | Final beat of a read response |
| r_vid_i | input | 3 | Output ID of the read response |
| r_id_o | output | 12 | Restored input ID of the read response |
| aw_valid_i | input | 1 | Write address valid |
| aw_id_i | input | 12 | Write address input ID |
| aw_ready_o | output | 1 | Write address accepted when high with valid |
| aw_vid_o | output | 3 | Output ID chosen for the write |
| b_valid_i | input | 1 | Write response valid |
| b_vid_i | input | 3 | Output ID of the write response |
| b_id_o | output | 12 | Restored input ID of the write response |
| cfg_we_i | input | 1 | Mapping register write strobe |
| cfg_wr_i | input | 1 | Table select: 0 read, 1 write |
| cfg_vid_i | input | 3 | Output ID whose register is written |
| cfg_force_i | input | 1 | Requested fixed-mapping enable |
| cfg_mid_i | input | 12 | Requested pinned input ID |
| rd_done_o | output | 8 | Per output ID: last read-table write applied |
| wr_done_o | output | 8 | Per output ID: last write-table write applied |
| rd_fixed_o | output | 8 | Per output ID: applied read fixed bit |
| wr_fixed_o | output | 8 | Per output ID: applied write fixed bit |

## Verification
The assertions assume a well-behaved upstream and downstream. A response arrives only on an output ID that has something outstanding, so the counts never go below zero. The address ID stays put while valid waits for ready. The bench keeps to this: it sends a response only after the matching address was accepted, and it holds each address for a single cycle, in which it checks ready. It drains every output ID before it moves to the next scenario.

// File: rtl/axi_id_remap_pkg.sv
package axi_id_remap_pkg;
  localparam int unsigned DEF_IN_W  = 12;
  localparam int unsigned DEF_VID_W = 3;
  localparam int unsigned DEF_CNT_W = 4;
  localparam int unsigned DEF_FIX_LO = 2;
  localparam int unsigned DEF_FIX_HI = 6;

  typedef enum logic {
    TBL_READ  = 1'b0,
    TBL_WRITE = 1'b1
  } tbl_sel_e;
endpackage

// File: rtl/remap_slot.sv
module remap_slot #(
  parameter int unsigned IN_W  = 12,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_hit,
  input  logic             cfg_force,
  input  logic [IN_W-1:0]  cfg_mid,
  input  logic             acc,
  input  logic [IN_W-1:0]  acc_id,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_o,
  output logic [IN_W-1:0]  tag_o,
  output logic             fixed_o,
  output logic             pend_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [IN_W-1:0]  tag_q;
  logic [IN_W-1:0]  pmid_q;
  logic             pforce_q;
  logic             pend_q;
  logic             fixed_q;
  logic             done_q;
  logic             apply;

  // a waiting change lands once the slot has drained and is idle this cycle
  assign apply = pend_q && (cnt_q == '0) && !acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (acc && !dec) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (!acc && dec) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
    end else if (acc) begin
      tag_q <= acc_id;
    end else if (apply && pforce_q) begin
      tag_q <= pmid_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      pforce_q <= 1'b0;
      pmid_q   <= '0;
      fixed_q  <= 1'b0;
      done_q   <= 1'b0;
    end else if (cfg_hit) begin
      pend_q   <= 1'b1;
      pforce_q <= cfg_force;
      pmid_q   <= cfg_mid;
      done_q   <= 1'b0;
    end else if (apply) begin
      pend_q  <= 1'b0;
      fixed_q <= pforce_q;
      done_q  <= 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign tag_o   = tag_q;
  assign fixed_o = fixed_q;
  assign pend_o  = pend_q;
  assign done_o  = done_q;
endmodule

// File: rtl/remap_chan.sv
module remap_chan #(
  parameter int unsigned IN_W   = 12,
  parameter int unsigned VID_W  = 3,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned FIX_LO = 2,
  parameter int unsigned FIX_HI = 6,
  localparam int unsigned NS    = 1 << VID_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_valid,
  input  logic [IN_W-1:0]  a_id,
  output logic             a_ready,
  output logic [VID_W-1:0] a_vid,
  input  logic             rsp_dec,
  input  logic [VID_W-1:0] rsp_vid,
  output logic [IN_W-1:0]  rsp_id,
  input  logic             cfg_we,
  input  logic [VID_W-1:0] cfg_vid,
  input  logic             cfg_force,
  input  logic [IN_W-1:0]  cfg_mid,
  output logic [NS-1:0]    done_o,
  output logic [NS-1:0]    fixed_o
);
  localparam logic [CNT_W-1:0] FULL = '1;

  logic [CNT_W-1:0] cnt   [NS];
  logic [IN_W-1:0]  tag   [NS];
  logic [NS-1:0]    fixed;
  logic [NS-1:0]    pend;
  logic [NS-1:0]    done;
  logic [NS-1:0]    cfg_hit;
  logic [NS-1:0]    acc;
  logic [NS-1:0]    dec;

  for (genvar s = 0; s < NS; s++) begin : g_slot
    localparam bit FIXABLE = (s >= FIX_LO) && (s <= FIX_HI);
    assign cfg_hit[s] = FIXABLE && cfg_we && (cfg_vid == VID_W'(s));
    assign acc[s]     = a_valid && a_ready && (a_vid == VID_W'(s));
    assign dec[s]     = rsp_dec && (rsp_vid == VID_W'(s));

    remap_slot #(.IN_W(IN_W), .CNT_W(CNT_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .cfg_hit  (cfg_hit[s]),
      .cfg_force(cfg_force),
      .cfg_mid  (cfg_mid),
      .acc      (acc[s]),
      .acc_id   (a_id),
      .dec      (dec[s]),
      .cnt_o    (cnt[s]),
      .tag_o    (tag[s]),
      .fixed_o  (fixed[s]),
      .pend_o   (pend[s]),
      .done_o   (done[s])
    );
  end

  logic             dhit_any, fhit_any, free_any;
  logic [VID_W-1:0] dhit_v, fhit_v, free_v;

  // scan downward so the lowest matching slot is the one left standing
  always_comb begin
    dhit_any = 1'b0;
    fhit_any = 1'b0;
    free_any = 1'b0;
    dhit_v   = '0;
    fhit_v   = '0;
    free_v   = '0;
    for (int s = NS - 1; s >= 0; s--) begin
      if (!fixed[s] && (cnt[s] != '0) && (tag[s] == a_id)) begin
        dhit_any = 1'b1;
        dhit_v   = VID_W'(s);
      end
      if (fixed[s] && (tag[s] == a_id)) begin
        fhit_any = 1'b1;
        fhit_v   = VID_W'(s);
      end
      if (!fixed[s] && !pend[s] && (cnt[s] == '0)) begin
        free_any = 1'b1;
        free_v   = VID_W'(s);
      end
    end
  end

  // outstanding dynamic use wins over a pin, so one ID never splits
  always_comb begin
    if (dhit_any) begin
      a_vid   = dhit_v;
      a_ready = !pend[dhit_v] && (cnt[dhit_v] != FULL);
    end else if (fhit_any) begin
      a_vid   = fhit_v;
      a_ready = !pend[fhit_v] && (cnt[fhit_v] != FULL);
    end else begin
      a_vid   = free_v;
      a_ready = free_any;
    end
  end

  assign rsp_id  = tag[rsp_vid];
  assign done_o  = done;
  assign fixed_o = fixed;
endmodule

// File: rtl/axi_id_remap.sv
module axi_id_remap
  import axi_id_remap_pkg::*;
#(
  parameter int unsigned IN_W   = DEF_IN_W,
  parameter int unsigned VID_W  = DEF_VID_W,
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned FIX_LO = DEF_FIX_LO,
  parameter int unsigned FIX_HI = DEF_FIX_HI,
  localparam int unsigned NS    = 1 << VID_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ar_valid_i,
  input  logic [IN_W-1:0]  ar_id_i,
  output logic             ar_ready_o,
  output logic [VID_W-1:0] ar_vid_o,
  input  logic             r_valid_i,
  input  logic             r_last_i,
  input  logic [VID_W-1:0] r_vid_i,
  output logic [IN_W-1:0]  r_id_o,
  input  logic             aw_valid_i,
  input  logic [IN_W-1:0]  aw_id_i,
  output logic             aw_ready_o,
  output logic [VID_W-1:0] aw_vid_o,
  input  logic             b_valid_i,
  input  logic [VID_W-1:0] b_vid_i,
  output logic [IN_W-1:0]  b_id_o,
  input  logic             cfg_we_i,
  input  logic             cfg_wr_i,
  input  logic [VID_W-1:0] cfg_vid_i,
  input  logic             cfg_force_i,
  input  logic [IN_W-1:0]  cfg_mid_i,
  output logic [NS-1:0]    rd_done_o,
  output logic [NS-1:0]    wr_done_o,
  output logic [NS-1:0]    rd_fixed_o,
  output logic [NS-1:0]    wr_fixed_o
);
  logic rd_cfg_we, wr_cfg_we;

  assign rd_cfg_we = cfg_we_i && (tbl_sel_e'(cfg_wr_i) == TBL_READ);
  assign wr_cfg_we = cfg_we_i && (tbl_sel_e'(cfg_wr_i) == TBL_WRITE);

  remap_chan #(
    .IN_W(IN_W), .VID_W(VID_W), .CNT_W(CNT_W), .FIX_LO(FIX_LO), .FIX_HI(FIX_HI)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .a_valid  (ar_valid_i),
    .a_id     (ar_id_i),
    .a_ready  (ar_ready_o),
    .a_vid    (ar_vid_o),
    .rsp_dec  (r_valid_i && r_last_i),
    .rsp_vid  (r_vid_i),
    .rsp_id   (r_id_o),
    .cfg_we   (rd_cfg_we),
    .cfg_vid  (cfg_vid_i),
    .cfg_force(cfg_force_i),
    .cfg_mid  (cfg_mid_i),
    .done_o   (rd_done_o),
    .fixed_o  (rd_fixed_o)
  );

  remap_chan #(
    .IN_W(IN_W), .VID_W(VID_W), .CNT_W(CNT_W), .FIX_LO(FIX_LO), .FIX_HI(FIX_HI)
  ) u_wr (
    .clk      (clk),
    .rst      (rst),
    .a_valid  (aw_valid_i),
    .a_id     (aw_id_i),
    .a_ready  (aw_ready_o),
    .a_vid    (aw_vid_o),
    .rsp_dec  (b_valid_i),
    .rsp_vid  (b_vid_i),
    .rsp_id   (b_id_o),
    .cfg_we   (wr_cfg_we),
    .cfg_vid  (cfg_vid_i),
    .cfg_force(cfg_force_i),
    .cfg_mid  (cfg_mid_i),
    .done_o   (wr_done_o),
    .fixed_o  (wr_fixed_o)
  );
endmodule

// File: rtl/axi_id_remap_chk.sv
module axi_id_remap_chk #(
  parameter int unsigned IN_W   = 12,
  parameter int unsigned VID_W  = 3,
  parameter int unsigned FIX_LO = 2,
  parameter int unsigned FIX_HI = 6,
  localparam int unsigned NS    = 1 << VID_W
) (
  input logic             clk,
  input logic             rst,
  input logic             ar_valid_i,
  input logic [IN_W-1:0]  ar_id_i,
  input logic             ar_ready_o,
  input logic [VID_W-1:0] ar_vid_o,
  input logic             r_valid_i,
  input logic             r_last_i,
  input logic             aw_valid_i,
  input logic [IN_W-1:0]  aw_id_i,
  input logic             aw_ready_o,
  input logic [VID_W-1:0] aw_vid_o,
  input logic             b_valid_i,
  input logic             cfg_we_i,
  input logic             cfg_wr_i,
  input logic [VID_W-1:0] cfg_vid_i,
  input logic [NS-1:0]    rd_done_o,
  input logic [NS-1:0]    wr_done_o,
  input logic [NS-1:0]    rd_fixed_o,
  input logic [NS-1:0]    wr_fixed_o
);
  logic cfg_in_range;
  assign cfg_in_range = (cfg_vid_i >= VID_W'(FIX_LO)) && (cfg_vid_i <= VID_W'(FIX_HI));

  // R4: writing a register drops its done bit on the next edge
  assert_done_clear_rd_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_we_i && !cfg_wr_i && cfg_in_range) |=> !rd_done_o[$past(cfg_vid_i)]);
  assert_done_clear_wr_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_we_i && cfg_wr_i && cfg_in_range) |=> !wr_done_o[$past(cfg_vid_i)]);

  // R3: an applied mapping always comes with a rising done bit
  assert_fix_change_rd_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_fixed_o) |-> ((rd_done_o & ~$past(rd_done_o)) != '0));
  assert_fix_change_wr_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(wr_fixed_o) |-> ((wr_done_o & ~$past(wr_done_o)) != '0));

  // R6: back-to-back same ID with no completion in between keeps its output ID
  assert_same_vid_rd_R6: assert property (@(posedge clk) disable iff (rst)
    (ar_valid_i && ar_ready_o && $past(ar_valid_i && ar_ready_o) &&
     (ar_id_i == $past(ar_id_i)) && !$past(r_valid_i && r_last_i))
    |-> (ar_vid_o == $past(ar_vid_o)));
  assert_same_vid_wr_R6: assert property (@(posedge clk) disable iff (rst)
    (aw_valid_i && aw_ready_o && $past(aw_valid_i && aw_ready_o) &&
     (aw_id_i == $past(aw_id_i)) && !$past(b_valid_i))
    |-> (aw_vid_o == $past(aw_vid_o)));

  // R4: done stays set until its own register is written again
  for (genvar s = 0; s < NS; s++) begin : g_hold
    assert_done_hold_rd_R4: assert property (@(posedge clk) disable iff (rst)
      (rd_done_o[s] && !(cfg_we_i && !cfg_wr_i && (cfg_vid_i == VID_W'(s))))
      |=> rd_done_o[s]);
    assert_done_hold_wr_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_done_o[s] && !(cfg_we_i && cfg_wr_i && (cfg_vid_i == VID_W'(s))))
      |=> wr_done_o[s]);
  end
endmodule

bind axi_id_remap axi_id_remap_chk #(
  .IN_W(IN_W), .VID_W(VID_W), .FIX_LO(FIX_LO), .FIX_HI(FIX_HI)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ar_valid_i(ar_valid_i),
  .ar_id_i   (ar_id_i),
  .ar_ready_o(ar_ready_o),
  .ar_vid_o  (ar_vid_o),
  .r_valid_i (r_valid_i),
  .r_last_i  (r_last_i),
  .aw_valid_i(aw_valid_i),
  .aw_id_i   (aw_id_i),
  .aw_ready_o(aw_ready_o),
  .aw_vid_o  (aw_vid_o),
  .b_valid_i (b_valid_i),
  .cfg_we_i  (cfg_we_i),
  .cfg_wr_i  (cfg_wr_i),
  .cfg_vid_i (cfg_vid_i),
  .rd_done_o (rd_done_o),
  .wr_done_o (wr_done_o),
  .rd_fixed_o(rd_fixed_o),
  .wr_fixed_o(wr_fixed_o)
);

// File: tb/axi_id_remap_bench.sv
module axi_id_remap_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ar_valid_i = 1'b0;
  logic [11:0] ar_id_i = '0;
  logic        ar_ready_o;
  logic [2:0]  ar_vid_o;
  logic        r_valid_i = 1'b0;
  logic        r_last_i = 1'b0;
  logic [2:0]  r_vid_i = '0;
  logic [11:0] r_id_o;
  logic        aw_valid_i = 1'b0;
  logic [11:0] aw_id_i = '0;
  logic        aw_ready_o;
  logic [2:0]  aw_vid_o;
  logic        b_valid_i = 1'b0;
  logic [2:0]  b_vid_i = '0;
  logic [11:0] b_id_o;
  logic        cfg_we_i = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [2:0]  cfg_vid_i = '0;
  logic        cfg_force_i = 1'b0;
  logic [11:0] cfg_mid_i = '0;
  logic [7:0]  rd_done_o, wr_done_o, rd_fixed_o, wr_fixed_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  axi_id_remap u_axi_id_remap (
    .clk(clk), .rst(rst),
    .ar_valid_i(ar_valid_i), .ar_id_i(ar_id_i), .ar_ready_o(ar_ready_o), .ar_vid_o(ar_vid_o),
    .r_valid_i(r_valid_i), .r_last_i(r_last_i), .r_vid_i(r_vid_i), .r_id_o(r_id_o),
    .aw_valid_i(aw_valid_i), .aw_id_i(aw_id_i), .aw_ready_o(aw_ready_o), .aw_vid_o(aw_vid_o),
    .b_valid_i(b_valid_i), .b_vid_i(b_vid_i), .b_id_o(b_id_o),
    .cfg_we_i(cfg_we_i), .cfg_wr_i(cfg_wr_i), .cfg_vid_i(cfg_vid_i),
    .cfg_force_i(cfg_force_i), .cfg_mid_i(cfg_mid_i),
    .rd_done_o(rd_done_o), .wr_done_o(wr_done_o),
    .rd_fixed_o(rd_fixed_o), .wr_fixed_o(wr_fixed_o)
  );

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ar_send(input logic [11:0] id, input logic rdy, input logic [2:0] vid, input string what);
    ar_valid_i = 1'b1;
    ar_id_i    = id;
    #1;
    check({what, " ar ready"}, ar_ready_o, rdy);
    if (rdy) check({what, " ar vid"}, ar_vid_o, vid);
    tick();
    ar_valid_i = 1'b0;
  endtask

  task automatic aw_send(input logic [11:0] id, input logic rdy, input logic [2:0] vid, input string what);
    aw_valid_i = 1'b1;
    aw_id_i    = id;
    #1;
    check({what, " aw ready"}, aw_ready_o, rdy);
    if (rdy) check({what, " aw vid"}, aw_vid_o, vid);
    tick();
    aw_valid_i = 1'b0;
  endtask

  task automatic r_resp(input logic [2:0] vid, input logic last, input logic [11:0] id, input string what);
    r_valid_i = 1'b1;
    r_last_i  = last;
    r_vid_i   = vid;
    #1;
    check({what, " r id"}, r_id_o, id);
    tick();
    r_valid_i = 1'b0;
    r_last_i  = 1'b0;
  endtask

  task automatic b_resp(input logic [2:0] vid, input logic [11:0] id, input string what);
    b_valid_i = 1'b1;
    b_vid_i   = vid;
    #1;
    check({what, " b id"}, b_id_o, id);
    tick();
    b_valid_i = 1'b0;
  endtask

  task automatic cfg(input logic wr, input logic [2:0] vid, input logic force_en, input logic [11:0] mid);
    cfg_we_i    = 1'b1;
    cfg_wr_i    = wr;
    cfg_vid_i   = vid;
    cfg_force_i = force_en;
    cfg_mid_i   = mid;
    tick();
    cfg_we_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rd fixed", rd_fixed_o, 8'h00);
    check("R1 wr fixed", wr_fixed_o, 8'h00);
    check("R1 rd done", rd_done_o, 8'h00);
    check("R1 wr done", wr_done_o, 8'h00);
    ar_send(12'h123, 1'b1, 3'd0, "R1 first read");
  endtask

  task automatic t_dynamic();
    ar_send(12'h123, 1'b1, 3'd0, "R6 reuse a");
    ar_send(12'h456, 1'b1, 3'd1, "R7 next free");
    ar_send(12'h123, 1'b1, 3'd0, "R6 reuse b");
    r_resp(3'd0, 1'b1, 12'h123, "R9 slot0");
    r_resp(3'd1, 1'b0, 12'h456, "R9 slot1 beat");
    ar_send(12'h456, 1'b1, 3'd1, "R8 not last keeps count");
    r_resp(3'd1, 1'b1, 12'h456, "R9 slot1 a");
    r_resp(3'd1, 1'b1, 12'h456, "R9 slot1 b");
    r_resp(3'd0, 1'b1, 12'h123, "R9 slot0 b");
    r_resp(3'd0, 1'b1, 12'h123, "R9 slot0 c");
    ar_send(12'h777, 1'b1, 3'd0, "R7 lowest free after drain");
    r_resp(3'd0, 1'b1, 12'h777, "R9 slot0 d");
  endtask

  task automatic t_ignore();
    cfg(1'b0, 3'd7, 1'b1, 12'h055);
    cfg(1'b0, 3'd0, 1'b1, 12'h055);
    cfg(1'b1, 3'd1, 1'b1, 12'h033);
    tick();
    check("R2 rd fixed untouched", rd_fixed_o, 8'h00);
    check("R2 rd done untouched", rd_done_o, 8'h00);
    check("R2 wr fixed untouched", wr_fixed_o, 8'h00);
    ar_send(12'h055, 1'b1, 3'd0, "R2 slot7 stays dynamic");
    r_resp(3'd0, 1'b1, 12'h055, "R2 drain");
    aw_send(12'h033, 1'b1, 3'd0, "R2 slot1 stays dynamic");
    b_resp(3'd0, 12'h033, "R2 drain b");
  endtask

  task automatic t_fix_now();
    cfg(1'b0, 3'd3, 1'b1, 12'h081);
    check("R3 not applied yet", rd_fixed_o, 8'h00);
    check("R4 done low while pending", rd_done_o, 8'h00);
    tick();
    check("R3 applied when idle", rd_fixed_o, 8'h08);
    check("R4 done set", rd_done_o, 8'h08);
    ar_send(12'h081, 1'b1, 3'd3, "R5 pinned read");
    aw_send(12'h081, 1'b1, 3'd0, "R10 write table separate");
    check("R10 wr fixed", wr_fixed_o, 8'h00);
    r_resp(3'd3, 1'b1, 12'h081, "R9 pinned");
    b_resp(3'd0, 12'h081, "R9 write");
  endtask

  task automatic t_deferred();
    ar_send(12'h081, 1'b1, 3'd3, "R5 pinned again");
    cfg(1'b0, 3'd3, 1'b0, 12'h000);
    tick();
    tick();
    check("R3 old mapping held", rd_fixed_o[3], 1'b1);
    check("R4 done cleared on write", rd_done_o[3], 1'b0);
    ar_send(12'h081, 1'b0, 3'd3, "R11 pending slot stalls");
    r_resp(3'd3, 1'b1, 12'h081, "R9 drain pinned");
    check("R3 not on drain edge", rd_fixed_o[3], 1'b1);
    tick();
    check("R3 applied after drain", rd_fixed_o[3], 1'b0);
    check("R4 done after apply", rd_done_o[3], 1'b1);
    ar_send(12'h081, 1'b1, 3'd0, "R7 unpinned goes dynamic");
    r_resp(3'd0, 1'b1, 12'h081, "R9 drain");
  endtask

  task automatic t_exhaust();
    for (int s = 2; s <= 6; s++) cfg(1'b0, 3'(s), 1'b1, 12'h200 + 12'(s - 2));
    tick();
    check("R4 all pinned done", rd_done_o, 8'h7C);
    check("R7 slot7 never fixed", rd_fixed_o, 8'h7C);
    ar_send(12'h001, 1'b1, 3'd0, "R7 dyn 0");
    ar_send(12'h002, 1'b1, 3'd1, "R7 dyn 1");
    ar_send(12'h003, 1'b1, 3'd7, "R7 dyn 7");
    ar_send(12'h004, 1'b0, 3'd0, "R7 none free stalls");
    ar_send(12'h001, 1'b1, 3'd0, "R6 reuse while full");
    r_resp(3'd0, 1'b1, 12'h001, "R9 s0");
    r_resp(3'd0, 1'b1, 12'h001, "R9 s0 b");
    r_resp(3'd1, 1'b1, 12'h002, "R9 s1");
    r_resp(3'd7, 1'b1, 12'h003, "R9 s7");
    for (int i = 0; i < 15; i++) ar_send(12'h200, 1'b1, 3'd2, "R8 fill");
    ar_send(12'h200, 1'b0, 3'd2, "R8 full stalls");
    for (int i = 0; i < 15; i++) r_resp(3'd2, 1'b1, 12'h200, "R8 drain");
    ar_send(12'h200, 1'b1, 3'd2, "R8 accepts after drain");
    r_resp(3'd2, 1'b1, 12'h200, "R8 final");
  endtask

  task automatic t_write_pin();
    cfg(1'b1, 3'd6, 1'b1, 12'h051);
    tick();
    check("R10 wr fixed 6", wr_fixed_o, 8'h40);
    check("R10 wr done 6", wr_done_o, 8'h40);
    aw_send(12'h051, 1'b1, 3'd6, "R5 pinned write");
    b_resp(3'd6, 12'h051, "R9 pinned write");
    ar_send(12'h051, 1'b1, 3'd0, "R10 read not pinned");
    r_resp(3'd0, 1'b1, 12'h051, "R10 drain");
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    t_reset();
    t_dynamic();
    t_ignore();
    t_fix_now();
    t_deferred();
    t_exhaust();
    t_write_pin();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule